// File: doc/BRIEF.md
# Keyed Write-Protection Unlock Sequencer

This block holds a small file of protected 32-bit registers behind a key register on a simple write bus. A write to a protected register is accepted only when it comes straight after four ordered key writes. All four key writes must name that register's byte address and access size, and they must carry step numbers 0, 1, 2 and 3. Writes that arrive without an unlock, or that do not match it, are dropped and set a sticky violation flag. Reads are never blocked.

The bus is a word-addressed write strobe with byte enables and a combinational read port. The byte enables give both the access size and the byte lane of each write. The key address field is compared against the register's word address joined with the lowest enabled lane. The protected values also drive the `prot_q` output for the logic they configure.

Top module: `keyed_wr_guard`

## Requirements
- R1: After reset the key register reads 0 (idle), the status register reads 0, and protected register i holds `RST_BASE | i` (default `32'hA5C3_0000 | i`).
- R2: A key word carries the step number in bits [31:30], the size code in bits [29:28] (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes) and the target byte address in bits [14:0]. The key register sits at word address 0 and reads back the sequence state in bits [2:0]: 0 idle, 1/2/3 steps done, 4 armed.
- R3: Four key writes with steps 0,1,2,3 and equal address and size fields arm the block. A following 4-byte write (byte enables 4'b1111) to the matching protected register then updates that register and returns the state to idle.
- R4: After an unlock for size 1 or 2, a matching write updates only its enabled bytes. The lanes are one byte (enables 0001, 0010, 0100 or 1000) or an aligned half (0011 or 1100), and the address field is the word byte address plus the lowest enabled lane.
- R5: A key write whose step is not the next expected one, and not 0, returns the state to idle.
- R6: A key write for step 1, 2 or 3 whose address or size field differs from the stored step-0 values returns the state to idle.
- R7: A key write carrying step 0 always restarts the sequence at state 1 and stores its fields.
- R8: Any write to an address other than the key register, including the status register or an unmapped address, returns the state to idle.
- R9: In the armed state, a write to a protected register with a wrong address or size is dropped, disarms the block and sets the violation flag.
- R10: A write to a protected register (word addresses 0x40 + i) without an armed matching unlock is ignored and sets the violation flag (status bit 0, word address 1). The flag stays set until a status write with bit 0 = 1; a status write with bit 0 = 0 leaves it set.
- R11: Protected registers read back their values in every state, and a read does not change the sequence state.
- R12: Byte-enable patterns other than the one-byte, aligned two-byte and full-word forms never match an armed sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_waddr | input | 13 | Word address (byte address bits [14:2]) |
| bus_be | input | 4 | Byte enables of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_waddr`, combinational |
| prot_q | output | NREG*32 | Protected register values, register i at bits [32*i+31:32*i] |
| violation | output | 1 | Sticky violation flag |

## Verification
The hardest states to reach are a partly unlocked or armed sequence that is then disturbed at exactly one point: a wrong step, a changed field, a restart, a foreign write or a mismatched armed write. Each task builds the key sequence one write at a time and reads the key register between steps, so every state the sequencer passes through is confirmed before the disturbing write. The task then shows through the register read-back that no protected byte changed. A model of the register file in the bench tracks the expected contents across all scenarios, so a stray update in one test shows up in later reads.

// File: rtl/kwg_pkg.sv
package kwg_pkg;
    localparam int KEY_ADDR_W = 15;
    localparam int WADDR_W    = KEY_ADDR_W - 2;

    localparam logic [WADDR_W-1:0] KEY_WADDR  = 13'h0000;
    localparam logic [WADDR_W-1:0] STAT_WADDR = 13'h0001;
    localparam logic [WADDR_W-1:0] PROT_WBASE = 13'h0040;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_K1    = 3'd1,
        ST_K2    = 3'd2,
        ST_K3    = 3'd3,
        ST_ARMED = 3'd4
    } seq_st_e;

    typedef struct packed {
        logic       ok;
        logic [1:0] code;
        logic [1:0] lane;
    } acc_t;
endpackage

// File: rtl/kwg_be_decode.sv
module kwg_be_decode
    import kwg_pkg::*;
(
    input  logic [3:0] be,
    output acc_t       acc
);
    always_comb begin
        acc = '{ok: 1'b1, code: 2'd0, lane: 2'd0};
        case (be)
            4'b0001: acc = '{ok: 1'b1, code: 2'd0, lane: 2'd0};
            4'b0010: acc = '{ok: 1'b1, code: 2'd0, lane: 2'd1};
            4'b0100: acc = '{ok: 1'b1, code: 2'd0, lane: 2'd2};
            4'b1000: acc = '{ok: 1'b1, code: 2'd0, lane: 2'd3};
            4'b0011: acc = '{ok: 1'b1, code: 2'd1, lane: 2'd0};
            4'b1100: acc = '{ok: 1'b1, code: 2'd1, lane: 2'd2};
            4'b1111: acc = '{ok: 1'b1, code: 2'd2, lane: 2'd0};
            default: acc = '{ok: 1'b0, code: 2'd3, lane: 2'd0};
        endcase
    end
endmodule

// File: rtl/kwg_key_seq.sv
module kwg_key_seq
    import kwg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic                  is_key,
    input  logic                  is_prot,
    input  logic [1:0]            key_step,
    input  logic [1:0]            key_code,
    input  logic [KEY_ADDR_W-1:0] key_addr,
    input  acc_t                  acc,
    input  logic [KEY_ADDR_W-1:0] acc_addr,
    output seq_st_e               state,
    output logic                  grant
);
    typedef struct packed {
        seq_st_e               st;
        logic [KEY_ADDR_W-1:0] addr;
        logic [1:0]            code;
    } seq_t;

    seq_t seq_d, seq_q;
    logic next_step;
    logic fields_eq;

    always_comb begin
        seq_d     = seq_q;
        grant     = 1'b0;
        fields_eq = (key_addr == seq_q.addr) && (key_code == seq_q.code);
        next_step = (seq_q.st == ST_K1 && key_step == 2'd1) ||
                    (seq_q.st == ST_K2 && key_step == 2'd2) ||
                    (seq_q.st == ST_K3 && key_step == 2'd3);
        if (wr) begin
            if (is_key) begin
                if (key_step == 2'd0) begin
                    seq_d.st   = ST_K1;
                    seq_d.addr = key_addr;
                    seq_d.code = key_code;
                end else if (next_step && fields_eq) begin
                    seq_d.st = seq_st_e'(seq_q.st + 3'd1);
                end else begin
                    seq_d.st = ST_IDLE;
                end
            end else begin
                seq_d.st = ST_IDLE;
                grant    = (seq_q.st == ST_ARMED) && is_prot && acc.ok &&
                           (acc_addr == seq_q.addr) && (acc.code == seq_q.code);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, addr: '0, code: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state = seq_q.st;
endmodule

// File: rtl/kwg_prot_file.sv
module kwg_prot_file #(
    parameter int          NREG     = 4,
    parameter logic [31:0] RST_BASE = 32'hA5C3_0000,
    localparam int         IDX_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [3:0]       be,
    input  logic [31:0]      wdata,
    output logic [31:0]      regs [NREG]
);
    logic [31:0] regs_d [NREG];
    logic [31:0] regs_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
            if (we && (32'(idx) == i)) begin
                for (int b = 0; b < 4; b++) begin
                    if (be[b]) regs_d[i][b*8 +: 8] = wdata[b*8 +: 8];
                end
            end
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= RST_BASE | 32'(g);
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end
        assign regs[g] = regs_q[g];
    end
endmodule

// File: rtl/keyed_wr_guard.sv
module keyed_wr_guard
    import kwg_pkg::*;
#(
    parameter int          NREG     = 4,
    parameter logic [31:0] RST_BASE = 32'hA5C3_0000,
    localparam int         IDX_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [12:0]        bus_waddr,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NREG*32-1:0] prot_q,
    output logic               violation
);
    acc_t                  acc;
    logic [WADDR_W-1:0]    rel;
    logic                  is_key, is_stat, is_prot;
    logic [IDX_W-1:0]      idx;
    logic [KEY_ADDR_W-1:0] acc_addr;
    seq_st_e               seq_state;
    logic                  grant;
    logic [31:0]           regs [NREG];
    logic                  viol_d, viol_q;

    assign rel      = bus_waddr - PROT_WBASE;
    assign is_key   = (bus_waddr == KEY_WADDR);
    assign is_stat  = (bus_waddr == STAT_WADDR);
    assign is_prot  = (bus_waddr >= PROT_WBASE) && (32'(rel) < NREG);
    assign idx      = IDX_W'(rel);
    assign acc_addr = {bus_waddr, acc.lane};

    kwg_be_decode u_dec (
        .be  (bus_be),
        .acc (acc)
    );

    kwg_key_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .is_key   (is_key),
        .is_prot  (is_prot),
        .key_step (bus_wdata[31:30]),
        .key_code (bus_wdata[29:28]),
        .key_addr (bus_wdata[KEY_ADDR_W-1:0]),
        .acc      (acc),
        .acc_addr (acc_addr),
        .state    (seq_state),
        .grant    (grant)
    );

    kwg_prot_file #(.NREG(NREG), .RST_BASE(RST_BASE)) u_file (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (grant),
        .idx   (idx),
        .be    (bus_be),
        .wdata (bus_wdata),
        .regs  (regs)
    );

    always_comb begin
        viol_d = viol_q;
        if (bus_wr && is_stat && bus_wdata[0]) viol_d = 1'b0;
        if (bus_wr && is_prot && !grant)       viol_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) viol_q <= 1'b0;
        else        viol_q <= viol_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (is_key)       bus_rdata = {29'd0, seq_state};
        else if (is_stat) bus_rdata = {31'd0, viol_q};
        else if (is_prot) bus_rdata = regs[idx];
    end

    for (genvar g = 0; g < NREG; g++) begin : g_out
        assign prot_q[g*32 +: 32] = regs[g];
    end

    assign violation = viol_q;
endmodule

// File: rtl/kwg_checker.sv
module kwg_checker #(
    parameter int NREG = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [12:0]        bus_waddr,
    input logic [1:0]         key_step,
    input logic               clr_bit,
    input logic [2:0]         seq_state,
    input logic [NREG*32-1:0] prot_q,
    input logic               violation
);
    // R3: protected values change only out of the armed state
    p_update_when_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_q) |-> $past(seq_state) == 3'd4);

    // R2: state encoding stays within idle..armed
    p_state_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state <= 3'd4);

    // R5: armed is only entered from the third step
    p_arm_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_state == 3'd4) |-> $past(seq_state) == 3'd3);

    // R7: step 0 key write restarts the sequence
    p_step0_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_waddr == 13'h0 && key_step == 2'd0) |=> seq_state == 3'd1);

    // R8: any non-key write leaves the sequencer idle
    p_foreign_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_waddr != 13'h0) |=> seq_state == 3'd0);

    // R10: violation flag is sticky until a clearing status write
    p_viol_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (violation && !(bus_wr && bus_waddr == 13'h1 && clr_bit)) |=> violation);
endmodule

bind keyed_wr_guard kwg_checker #(.NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_waddr (bus_waddr),
    .key_step  (bus_wdata[31:30]),
    .clr_bit   (bus_wdata[0]),
    .seq_state (seq_state),
    .prot_q    (prot_q),
    .violation (violation)
);

// File: tb/keyed_wr_guard_test.sv
`timescale 1ns/1ps
module keyed_wr_guard_test;
    localparam int NREG = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_wr = 1'b0;
    logic [12:0]        bus_waddr = '0;
    logic [3:0]         bus_be = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [NREG*32-1:0] prot_q;
    logic               violation;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [NREG];

    always #2 clk = ~clk;

    keyed_wr_guard #(.NREG(NREG)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_waddr (bus_waddr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .prot_q    (prot_q),
        .violation (violation)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        bus_waddr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] kw(input logic [1:0] step, input logic [1:0] code,
                                       input logic [14:0] a);
        return {step, code, 13'd0, a};
    endfunction

    task automatic key(input logic [1:0] step, input logic [1:0] code, input logic [14:0] a);
        wr(13'h0, 4'hF, kw(step, code, a));
    endtask

    task automatic unlock(input logic [1:0] code, input logic [14:0] a);
        for (int s = 0; s < 4; s++) key(2'(s), code, a);
    endtask

    task automatic chk_state(input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(13'h0, v);
        chk(v, exp, tag);
    endtask

    task automatic chk_regs(input string tag);
        logic [31:0] v;
        for (int i = 0; i < NREG; i++) begin
            rd(13'h40 + 13'(i), v);
            chk(v, model[i], tag);
            chk(prot_q[i*32 +: 32], model[i], tag);
        end
    endtask

    task automatic chk_viol(input logic exp, input string tag);
        logic [31:0] v;
        rd(13'h1, v);
        chk(v, {31'd0, exp}, tag);
        chk({31'd0, violation}, {31'd0, exp}, tag);
    endtask

    task automatic clear_viol();
        wr(13'h1, 4'hF, 32'h1);
    endtask

    task automatic t_reset();
        chk_state(32'd0, "R1 idle after reset");
        chk_viol(1'b0, "R1 violation clear after reset");
        chk_regs("R1 reset values");
    endtask

    task automatic t_full_word();
        key(2'd0, 2'd2, 15'h104); chk_state(32'd1, "R2 state after step0");
        key(2'd1, 2'd2, 15'h104); chk_state(32'd2, "R2 state after step1");
        key(2'd2, 2'd2, 15'h104); chk_state(32'd3, "R2 state after step2");
        key(2'd3, 2'd2, 15'h104); chk_state(32'd4, "R2 armed after step3");
        wr(13'h41, 4'hF, 32'h1234_5678);
        model[1] = 32'h1234_5678;
        chk_regs("R3 full word update");
        chk_state(32'd0, "R3 idle after protected write");
        chk_viol(1'b0, "R3 no violation on granted write");
    endtask

    task automatic t_partial();
        unlock(2'd0, 15'h10A);
        wr(13'h42, 4'b0100, 32'hFFEE_DDCC);
        model[2][23:16] = 8'hEE;
        chk_regs("R4 single byte lane 2");
        unlock(2'd1, 15'h10E);
        wr(13'h43, 4'b1100, 32'hBEEF_0000);
        model[3][31:16] = 16'hBEEF;
        chk_regs("R4 upper half word");
        chk_viol(1'b0, "R4 no violation");
    endtask

    task automatic t_order();
        key(2'd0, 2'd2, 15'h100);
        key(2'd2, 2'd2, 15'h100);
        chk_state(32'd0, "R5 skipped step returns idle");
        key(2'd1, 2'd2, 15'h100);
        chk_state(32'd0, "R5 step1 from idle stays idle");
        wr(13'h40, 4'hF, 32'hDEAD_0001);
        chk_regs("R10 write without unlock ignored");
        chk_viol(1'b0 | 1'b1, "R10 violation set");
        wr(13'h1, 4'hF, 32'h0);
        chk_viol(1'b1, "R10 writing 0 keeps flag");
        clear_viol();
        chk_viol(1'b0, "R10 writing 1 clears flag");
    endtask

    task automatic t_mismatch();
        key(2'd0, 2'd2, 15'h100);
        key(2'd1, 2'd2, 15'h104);
        chk_state(32'd0, "R6 address change aborts");
        key(2'd0, 2'd2, 15'h100);
        key(2'd1, 2'd2, 15'h100);
        key(2'd2, 2'd1, 15'h100);
        chk_state(32'd0, "R6 size change aborts");
    endtask

    task automatic t_restart();
        key(2'd0, 2'd2, 15'h104);
        key(2'd1, 2'd2, 15'h104);
        key(2'd2, 2'd2, 15'h104);
        key(2'd0, 2'd2, 15'h100);
        chk_state(32'd1, "R7 step0 restarts");
        key(2'd1, 2'd2, 15'h100);
        key(2'd2, 2'd2, 15'h100);
        key(2'd3, 2'd2, 15'h100);
        chk_state(32'd4, "R7 armed after restart");
        wr(13'h40, 4'hF, 32'h0BAD_F00D);
        model[0] = 32'h0BAD_F00D;
        chk_regs("R7 write after restarted unlock");
    endtask

    task automatic t_intervene();
        key(2'd0, 2'd2, 15'h100);
        key(2'd1, 2'd2, 15'h100);
        wr(13'h1, 4'hF, 32'h0);
        chk_state(32'd0, "R8 status write aborts sequence");
        unlock(2'd2, 15'h100);
        wr(13'h200, 4'hF, 32'h5555_5555);
        chk_state(32'd0, "R8 unmapped write disarms");
        wr(13'h40, 4'hF, 32'h7777_7777);
        chk_regs("R8 protected write after disarm ignored");
        chk_viol(1'b1, "R8 violation after disarmed write");
        clear_viol();
    endtask

    task automatic t_armed_bad();
        logic [31:0] v;
        unlock(2'd2, 15'h100);
        rd(13'h40, v);
        chk(v, model[0], "R11 read while armed");
        chk_state(32'd4, "R11 read keeps armed");
        wr(13'h41, 4'hF, 32'h1111_1111);
        chk_regs("R9 wrong address dropped");
        chk_state(32'd0, "R9 wrong address disarms");
        chk_viol(1'b1, "R9 wrong address sets flag");
        clear_viol();
        unlock(2'd2, 15'h100);
        wr(13'h40, 4'b0011, 32'h2222_2222);
        chk_regs("R9 wrong size dropped");
        chk_viol(1'b1, "R9 wrong size sets flag");
        clear_viol();
    endtask

    task automatic t_bad_be();
        unlock(2'd1, 15'h101);
        wr(13'h40, 4'b0110, 32'h3333_3333);
        chk_regs("R12 odd byte enables never match");
        chk_viol(1'b1, "R12 odd byte enables flagged");
        clear_viol();
        unlock(2'd2, 15'h100);
        wr(13'h40, 4'b0111, 32'h4444_4444);
        chk_regs("R12 three-byte enables never match");
        clear_viol();
        chk_viol(1'b0, "R12 flag cleared");
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = 32'hA5C3_0000 | 32'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_word();
        t_partial();
        t_order();
        t_mismatch();
        t_restart();
        t_intervene();
        t_armed_bad();
        t_bad_be();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule